// File: doc/BRIEF.md
# Multi-Pool Free Pointer Allocator

The block holds free buffer pointers for up to eight independent pools in a single shared pointer store. Each pool gets its own contiguous slice of that store and uses it as a circular FIFO. The slice length is set by a per-pool size register. Slices are packed in pool order, so a pool's slice begins where the slices of all lower-numbered pools end.

A client returns a buffer by issuing a free request: the pool number and the pointer travel with the request. A client obtains a buffer by issuing an allocate request for a pool. One cycle later the block answers with the oldest pointer held by that pool, or with zero when the pool is empty. Each pool also exposes its current occupancy, a high and a low watermark flag, and a sticky overflow flag. A global enable input gates all request service. Any change of a size register puts the block into a short settling stall.

Top module: `ptr_pool_alloc`

## Requirements
- R1: After reset, every size is 0, every high mark is 2047 and every low mark is 0. With `en` high, `ready` is 1 and `rsp_valid` is 0. All occupancy fields are 0, and all flags (`hi_flag`, `lo_flag`, `ovf_flag`) are 0.
- R2: Bit 0 of a written size is ignored, so the effective size is `size_val & ~1`. A pool holds at most its effective size minus 2 pointers, or none if the effective size is below 2. Pools occupy disjoint regions, so traffic in one pool never alters pointers held by another.
- R3: `ready` is 0 in a cycle where `size_we` is 1 and for the 10 cycles that follow it. That size write also empties every pool.
- R4: An accepted allocate request (`req_valid` and `ready` both 1, `req_free` = 0) raises `rsp_valid` for exactly the next cycle. The pointers of a pool come back in the order in which they were freed.
- R5: An allocate request to an empty pool is answered with `rsp_ptr` = 0.
- R6: A free request that carries a zero pointer leaves every pool unchanged.
- R7: A free request to a pool that is already at capacity is dropped and sets that pool's bit in `ovf_flag`. Only reset clears that bit; a size write does not.
- R8: While `en` is 0, `ready` is 0. Requests are not accepted, no response is produced, and occupancy does not change.
- R9: Pool p's occupancy appears as a 26-bit count at `avail[26*p +: 26]`. It rises by 1 on each stored free and falls by 1 on each successful allocate.
- R10: Pool p's `hi_flag[p]` is 1 exactly when its occupancy exceeds its high mark. Its `lo_flag[p]` is 1 exactly when its occupancy is below its low mark. A `mark_we` write sets both marks of pool `mark_pool`.
- R11: Read and write positions wrap modulo the effective size. FIFO order is preserved across any number of wraparounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| size_we | input | 1 | Size register write strobe |
| size_pool | input | 3 | Pool addressed by a size write |
| size_val | input | 12 | Size value (bit 0 ignored) |
| mark_we | input | 1 | Watermark write strobe |
| mark_pool | input | 3 | Pool addressed by a watermark write |
| mark_hi | input | 11 | High watermark |
| mark_lo | input | 11 | Low watermark |
| req_valid | input | 1 | Request present |
| req_free | input | 1 | 1 = free request, 0 = allocate request |
| req_pool | input | 3 | Target pool |
| req_ptr | input | 32 | Pointer being freed |
| ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Allocate response valid |
| rsp_ptr | output | 32 | Allocated pointer, or 0 |
| avail | output | 208 | Per-pool occupancy, 26 bits per pool |
| hi_flag | output | 8 | Occupancy above high mark |
| lo_flag | output | 8 | Occupancy below low mark |
| ovf_flag | output | 8 | Sticky dropped-free flag |

## Verification
Most internal faults reach the ports quickly. A wrong base or index sum makes a later allocate return another pool's pointer, or return pointers out of order. The scoreboard catches that on the cycle after the request. A wrong occupancy count shows at once on `avail` and the watermark flags. It also shifts the point where frees start to overflow, or where allocates return zero. A stall counter that is off by one changes the length of the low stretch on `ready` after a size write, and that length is measured exactly.

// File: rtl/ptr_pool_alloc.sv
module ptr_pool_alloc #(
  parameter int NPOOL = 8,
  parameter int DEPTH = 2048,
  parameter int PW    = 32,
  parameter int SZW   = 12,
  parameter int MKW   = 11,
  parameter int AVW   = 26,
  parameter int STALL = 10,
  localparam int PSW  = $clog2(NPOOL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 size_we,
  input  logic [PSW-1:0]       size_pool,
  input  logic [SZW-1:0]       size_val,
  input  logic                 mark_we,
  input  logic [PSW-1:0]       mark_pool,
  input  logic [MKW-1:0]       mark_hi,
  input  logic [MKW-1:0]       mark_lo,
  input  logic                 req_valid,
  input  logic                 req_free,
  input  logic [PSW-1:0]       req_pool,
  input  logic [PW-1:0]        req_ptr,
  output logic                 ready,
  output logic                 rsp_valid,
  output logic [PW-1:0]        rsp_ptr,
  output logic [NPOOL*AVW-1:0] avail,
  output logic [NPOOL-1:0]     hi_flag,
  output logic [NPOOL-1:0]     lo_flag,
  output logic [NPOOL-1:0]     ovf_flag
);
  localparam int AW  = $clog2(DEPTH);
  localparam int BW  = SZW + PSW;
  localparam int STW = $clog2(STALL + 1);

  logic [SZW-1:0] size_q [NPOOL];
  logic [SZW-1:0] rd_q   [NPOOL];
  logic [SZW-1:0] wr_q   [NPOOL];
  logic [SZW-1:0] cnt_q  [NPOOL];
  logic [SZW-1:0] cap    [NPOOL];
  logic [MKW-1:0] hi_q   [NPOOL];
  logic [MKW-1:0] lo_q   [NPOOL];
  logic [BW-1:0]  base   [NPOOL];
  logic [PW-1:0]  mem    [DEPTH];
  logic [STW-1:0] stall_q;

  function automatic logic [SZW-1:0] step(input logic [SZW-1:0] i, input logic [SZW-1:0] lim);
    return (i + SZW'(1) >= lim) ? '0 : i + SZW'(1);
  endfunction

  always_comb begin
    logic [BW-1:0] acc;
    acc = '0;
    for (int p = 0; p < NPOOL; p++) begin
      base[p] = acc;
      acc     = acc + BW'(size_q[p]);
      cap[p]  = (size_q[p] >= SZW'(2)) ? size_q[p] - SZW'(2) : '0;
    end
  end

  assign ready = en && (stall_q == '0) && !size_we;

  logic take, do_alloc, do_free, room, rd_ok, wr_ok, nz;
  logic [AW-1:0] rd_addr, wr_addr;

  assign take     = req_valid && ready;
  assign do_alloc = take && !req_free;
  assign do_free  = take && req_free;
  assign nz       = req_ptr != '0;
  assign room     = cnt_q[req_pool] < cap[req_pool];
  assign rd_ok    = do_alloc && (cnt_q[req_pool] != '0);
  assign wr_ok    = do_free && nz && room;
  assign rd_addr  = AW'(base[req_pool] + BW'(rd_q[req_pool]));
  assign wr_addr  = AW'(base[req_pool] + BW'(wr_q[req_pool]));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= req_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ptr   <= '0;
    end else begin
      rsp_valid <= do_alloc;
      rsp_ptr   <= rd_ok ? mem[rd_addr] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q  <= '0;
      ovf_flag <= '0;
      for (int p = 0; p < NPOOL; p++) begin
        size_q[p] <= '0;
        rd_q[p]   <= '0;
        wr_q[p]   <= '0;
        cnt_q[p]  <= '0;
        hi_q[p]   <= '1;
        lo_q[p]   <= '0;
      end
    end else begin
      if (stall_q != '0) stall_q <= stall_q - STW'(1);
      if (mark_we) begin
        hi_q[mark_pool] <= mark_hi;
        lo_q[mark_pool] <= mark_lo;
      end
      if (size_we) begin
        stall_q <= STW'(STALL);
        size_q[size_pool] <= size_val & ~SZW'(1);
        for (int p = 0; p < NPOOL; p++) begin
          rd_q[p]  <= '0;
          wr_q[p]  <= '0;
          cnt_q[p] <= '0;
        end
      end else if (rd_ok) begin
        rd_q[req_pool]  <= step(rd_q[req_pool], size_q[req_pool]);
        cnt_q[req_pool] <= cnt_q[req_pool] - SZW'(1);
      end else if (wr_ok) begin
        wr_q[req_pool]  <= step(wr_q[req_pool], size_q[req_pool]);
        cnt_q[req_pool] <= cnt_q[req_pool] + SZW'(1);
      end
      if (do_free && nz && !room) ovf_flag[req_pool] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NPOOL; g++) begin : g_pool
    assign avail[g*AVW +: AVW] = AVW'(cnt_q[g]);
    assign hi_flag[g] = cnt_q[g] > SZW'(hi_q[g]);
    assign lo_flag[g] = cnt_q[g] < SZW'(lo_q[g]);
  end
endmodule

// File: rtl/ptr_pool_alloc_chk.sv
module ptr_pool_alloc_chk #(
  parameter int NPOOL = 8,
  parameter int AVW   = 26
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 size_we,
  input logic                 req_valid,
  input logic                 req_free,
  input logic                 ready,
  input logic                 rsp_valid,
  input logic [NPOOL*AVW-1:0] avail,
  input logic [NPOOL-1:0]     ovf_flag
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && !req_free) |=> rsp_valid); // R4
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && ready && !req_free) |=> !rsp_valid); // R4
  AST_SIZE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> !ready); // R3
  AST_SIZE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |-> !ready); // R3
  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ready); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag))); // R7
  AST_IDLE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && ready) && !size_we) |=> $stable(avail)); // R9
endmodule

bind ptr_pool_alloc ptr_pool_alloc_chk #(.NPOOL(NPOOL), .AVW(AVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .size_we(size_we),
  .req_valid(req_valid), .req_free(req_free), .ready(ready),
  .rsp_valid(rsp_valid), .avail(avail), .ovf_flag(ovf_flag)
);

// File: tb/test_ptr_pool_alloc.sv
module test_ptr_pool_alloc;
  localparam int NP = 8;
  localparam int AV = 26;

  logic clk = 0, rst_n = 0, en = 1;
  always #5 clk = ~clk;

  logic size_we = 0, mark_we = 0, req_valid = 0, req_free = 0;
  logic [2:0] size_pool = 0, mark_pool = 0, req_pool = 0;
  logic [11:0] size_val = 0;
  logic [10:0] mark_hi = 0, mark_lo = 0;
  logic [31:0] req_ptr = 0;
  logic ready, rsp_valid;
  logic [31:0] rsp_ptr;
  logic [NP*AV-1:0] avail;
  logic [NP-1:0] hi_flag, lo_flag, ovf_flag;

  ptr_pool_alloc i_ptr_pool_alloc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .size_we(size_we), .size_pool(size_pool), .size_val(size_val),
    .mark_we(mark_we), .mark_pool(mark_pool), .mark_hi(mark_hi), .mark_lo(mark_lo),
    .req_valid(req_valid), .req_free(req_free), .req_pool(req_pool), .req_ptr(req_ptr),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_ptr(rsp_ptr),
    .avail(avail), .hi_flag(hi_flag), .lo_flag(lo_flag), .ovf_flag(ovf_flag));

  int vectors = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] pool_m[NP][$];
  int cap_m[NP];
  int hi_m[NP];
  int lo_m[NP];
  logic [NP-1:0] ovf_m = '0;

  task automatic chk(string r, logic [63:0] a, logic [63:0] e);
    vectors++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, a, e);
    end
  endtask

  always @(negedge clk) begin : mon
    logic [31:0] e;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected response", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R4/R5 allocate data", rsp_ptr, e);
      end
    end
  end

  task automatic chk_state(string r);
    for (int p = 0; p < NP; p++) begin
      chk({r, " R9 occupancy"}, avail[p*AV +: AV], pool_m[p].size());
      chk({r, " R10 high flag"}, hi_flag[p], pool_m[p].size() > hi_m[p]);
      chk({r, " R10 low flag"}, lo_flag[p], pool_m[p].size() < lo_m[p]);
    end
    chk({r, " R7 overflow flags"}, ovf_flag, ovf_m);
  endtask

  task automatic set_size(int p, int v);
    int n;
    @(posedge clk); #1;
    size_we = 1; size_pool = 3'(p); size_val = 12'(v);
    @(negedge clk);
    chk("R3 ready during size write", ready, 0);
    @(posedge clk); #1;
    size_we = 0;
    cap_m[p] = ((v & ~1) >= 2) ? (v & ~1) - 2 : 0;
    for (int q = 0; q < NP; q++) pool_m[q].delete();
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
    chk("R3 stall length", n, 10);
  endtask

  task automatic set_mark(int p, int h, int l);
    @(posedge clk); #1;
    mark_we = 1; mark_pool = 3'(p); mark_hi = 11'(h); mark_lo = 11'(l);
    @(posedge clk); #1;
    mark_we = 0;
    hi_m[p] = h; lo_m[p] = l;
  endtask

  task automatic free_p(int p, logic [31:0] ptr);
    @(posedge clk); #1;
    req_valid = 1; req_free = 1; req_pool = 3'(p); req_ptr = ptr;
    @(posedge clk); #1;
    req_valid = 0;
    if (ptr != 0) begin
      if (pool_m[p].size() < cap_m[p]) pool_m[p].push_back(ptr);
      else ovf_m[p] = 1'b1;
    end
  endtask

  task automatic alloc_p(int p);
    @(posedge clk); #1;
    req_valid = 1; req_free = 0; req_pool = 3'(p); req_ptr = 0;
    @(posedge clk); #1;
    req_valid = 0;
    if (pool_m[p].size() > 0) exp_q.push_back(pool_m[p].pop_front());
    else exp_q.push_back(32'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin cap_m[p] = 0; hi_m[p] = 2047; lo_m[p] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R1 no response after reset", rsp_valid, 0);
    chk_state("R1 reset");

    set_size(0, 7);
    set_size(1, 4);
    set_size(2, 10);

    alloc_p(0);
    for (int i = 0; i < 5; i++) free_p(0, 32'h100 + i);
    chk_state("R7 full pool");
    free_p(1, 32'h0);
    chk_state("R6 zero pointer");
    free_p(1, 32'h200);
    free_p(1, 32'h201);
    for (int i = 0; i < 6; i++) free_p(2, 32'h300 + i);
    alloc_p(0); alloc_p(0); alloc_p(1); alloc_p(2);
    chk_state("R2 separate pools");

    for (int i = 0; i < 12; i++) begin
      free_p(0, 32'h400 + i);
      alloc_p(0);
    end
    chk_state("R11 wraparound");

    set_mark(2, 5, 4);
    chk_state("R10 marks set");
    alloc_p(2);
    chk_state("R10 at low mark");
    alloc_p(2);
    chk_state("R10 below low mark");
    free_p(2, 32'h500); free_p(2, 32'h501); free_p(2, 32'h502);
    chk_state("R10 above high mark");

    @(posedge clk); #1 en = 0;
    @(negedge clk);
    chk("R8 ready low when disabled", ready, 0);
    @(posedge clk); #1;
    req_valid = 1; req_free = 1; req_pool = 3'd2; req_ptr = 32'h777;
    @(posedge clk); #1;
    req_free = 0;
    @(posedge clk); #1;
    req_valid = 0;
    repeat (2) @(negedge clk);
    chk_state("R8 disabled");
    @(posedge clk); #1 en = 1;

    set_size(3, 8);
    chk_state("R3 pools emptied");
    alloc_p(2);
    alloc_p(0);
    repeat (3) @(negedge clk);
    chk("R4 all responses seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule